// File: doc/BRIEF.md
# Clocked Serial Byte Transceiver

This block is a byte-wide synchronous serial port run by a CPU through two registers on a small register bus. One is a control/status register. The other is a single data register shared by transmit and receive. Writing a transmit or receive enable bit starts an 8-bit transfer. The shift clock comes from one of two places. In internal mode a programmable divider generates it and the block drives it out on the clock pin. In external mode the same pin is an input, and the block synchronises it before using its edges.

When the eighth bit has moved, the enable bit clears itself and an end flag rises. If the interrupt enable is set, the end flag raises the interrupt request. The end flag is the only handshake. Any read or write of the data register clears it.

A stop input clears the end flag and the receive enable and aborts a receive in progress. The serial input pin is shared with a modem clear-to-send input. An external enable decides which of the two functions the pin serves.

Top module: `sync_byte_port`

## Requirements
- R1: After reset the control/status register reads 0x00, irq_o is 0, sclk_o is 1, sdo_o is 1 and sclk_oe_o is 1.
- R2: Control/status register (addr_i=0) layout: bit 7 end flag (read-only), bit 6 interrupt enable, bit 5 receive enable, bit 4 transmit enable, bit 3 reads 0, bits 2:0 clock select. A write to bit 7 or bit 3 has no effect.
- R3: A control write with bits 5 and 4 both 1 leaves both enables unchanged. An enable can only be set while the other one is 0, so the two are never 1 together.
- R4: Transmit shifts the data register (addr_i=1) out on sdo_o LSB first. sdo_o changes only after a falling shift-clock edge, is stable at each rising edge, and holds the last bit while idle.
- R5: Receive samples the serial data on each rising shift-clock edge, LSB first. After 8 bits the data register holds the first bit received in bit 0.
- R6: The eighth rising shift-clock edge clears the active enable and sets the end flag in the same cycle. In internal mode the end flag reads 1 exactly 16*(DIV_BASE<<sel) cycles after the enabling write takes effect.
- R7: irq_o is 1 exactly when the end flag and the interrupt enable are both 1.
- R8: A read or a write of the data register clears the end flag. A control register access does not.
- R9: stop_i clears the end flag and the receive enable and aborts the receive. The interrupt enable and the clock select keep their values.
- R10: Clock select values 0 to 6 give internal mode: sclk_oe_o=1 and sclk_o idles high, toggling every DIV_BASE<<sel cycles during a transfer. Value 7 gives external mode: sclk_oe_o=0, and the clock is taken from sclk_i through a two-flip-flop synchroniser.
- R11: With modem_en_i=1 the receiver sees constant 1s and cts_o follows sdi_i. With modem_en_i=0, cts_o is 1 and sdi_i is the receive data.
- R12: A data register write while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | I/O stop mode; clears end flag and receive enable |
| addr_i | input | 1 | Register select: 0 control/status, 1 data |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | End-of-transfer interrupt request |
| sclk_o | output | 1 | Internally generated shift clock |
| sclk_oe_o | output | 1 | Clock pin drive enable (1 in internal mode) |
| sclk_i | input | 1 | Shift clock from the pin in external mode |
| sdi_i | input | 1 | Shared serial data / modem clear-to-send pin |
| modem_en_i | input | 1 | Selects the modem function of sdi_i |
| cts_o | output | 1 | Modem clear-to-send as seen by the modem logic |
| sdo_o | output | 1 | Serial transmit data |

## Verification
The hardest cases are the collisions in time. A stop or a conflicting control write has to land while a transfer is still in flight, and a data write has to arrive mid-shift. The stimulus reaches these states with the slowest internal divider setting, which keeps a transfer open for thousands of cycles. It then fires the disturbing access a fixed number of cycles after the start. The external clock path is driven by hand with slow edges on sclk_i, so the synchroniser delay falls well inside each half period.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_EXT = 3'b111;
  localparam int unsigned EF_BIT  = 7;
  localparam int unsigned EIE_BIT = 6;
  localparam int unsigned RE_BIT  = 5;
  localparam int unsigned TE_BIT  = 4;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/sbp_clkgen.sv
module sbp_clkgen
  import sbp_pkg::*;
#(
  parameter int unsigned DIV_BASE = 2,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             ext_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sclk_pin_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned MAX_HALF = DIV_BASE << ((1 << SEL_W) - 2);
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0]  div_q;
  logic [CNT_W-1:0]  half_m1;
  logic              sclk_q;
  logic              tick;
  logic [SYNC_N:0]   sync_q;
  logic              ext_rise, ext_fall;

  assign half_m1 = CNT_W'((DIV_BASE << sel_i) - 1);
  assign tick    = active_i & ~ext_i & (div_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!active_i || ext_i) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // synchroniser stages plus one edge-detect stage
  for (genvar g = 0; g <= SYNC_N; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b1;
        else         sync_q[0] <= sclk_pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign ext_fall = ~sync_q[SYNC_N-1] & sync_q[SYNC_N];

  assign rise_o = ext_i ? (active_i & ext_rise) : (tick & ~sclk_q);
  assign fall_o = ext_i ? (active_i & ext_fall) : (tick & sclk_q);
  assign sclk_o = sclk_q;

  // R10
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> sclk_q);

  // R10
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/sbp_shifter.sv
module sbp_shifter
  import sbp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tx_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              sdo_o,
  output logic              shift_o,
  output logic              done_o
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic [CW-1:0] cnt_q;
  logic          sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (rise_i)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sdo_q <= 1'b1;
    else if (active_i && tx_i && fall_i) sdo_q <= data_i[cnt_q];
  end

  assign sdo_o   = sdo_q;
  assign shift_o = active_i & ~tx_i & rise_i;
  assign done_o  = active_i & rise_i & (cnt_q == CW'(BYTE_W - 1));

  // R4
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_q) |-> $past(fall_i && tx_i && active_i));
endmodule

// File: rtl/sync_byte_port.sv
module sync_byte_port
  import sbp_pkg::*;
#(
  parameter int unsigned DIV_BASE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              modem_en_i,
  output logic              cts_o,
  output logic              sdo_o
);
  logic              ef_q, eie_q, re_q, te_q;
  logic [SEL_W-1:0]  sel_q;
  logic [BYTE_W-1:0] data_q;
  logic              active, ext_mode, rise, fall, shift, done, rx_bit;
  logic              ctrl_wr, data_wr, data_acc, both_req;

  assign active   = re_q | te_q;
  assign ext_mode = (sel_q == SEL_EXT);
  assign ctrl_wr  = wr_en_i & (addr_i == ADDR_CTRL);
  assign data_wr  = wr_en_i & (addr_i == ADDR_DATA);
  assign data_acc = (wr_en_i | rd_en_i) & (addr_i == ADDR_DATA);
  assign both_req = wdata_i[RE_BIT] & wdata_i[TE_BIT];
  assign rx_bit   = modem_en_i ? 1'b1 : sdi_i;
  assign cts_o    = modem_en_i ? sdi_i : 1'b1;

  sbp_clkgen #(.DIV_BASE(DIV_BASE)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .ext_i      (ext_mode),
    .sel_i      (sel_q),
    .sclk_pin_i (sclk_i),
    .sclk_o     (sclk_o),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  sbp_shifter u_shf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tx_i     (te_q),
    .rise_i   (rise),
    .fall_i   (fall),
    .data_i   (data_q),
    .sdo_o    (sdo_o),
    .shift_o  (shift),
    .done_o   (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eie_q <= 1'b0;
      sel_q <= '0;
      re_q  <= 1'b0;
      te_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        eie_q <= wdata_i[EIE_BIT];
        sel_q <= wdata_i[SEL_W-1:0];
      end
      if (stop_i) begin
        re_q <= 1'b0;
      end else if (done) begin
        re_q <= 1'b0;
        te_q <= 1'b0;
      end else if (ctrl_wr && !both_req) begin
        re_q <= wdata_i[RE_BIT] & ~te_q;
        te_q <= wdata_i[TE_BIT] & ~re_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ef_q <= 1'b0;
    else if (stop_i)    ef_q <= 1'b0;
    else if (done)      ef_q <= 1'b1;
    else if (data_acc)  ef_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 data_q <= '0;
    else if (data_wr && !active) data_q <= wdata_i;
    else if (shift)              data_q <= {rx_bit, data_q[BYTE_W-1:1]};
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_DATA) begin
      rdata_o = data_q;
    end else begin
      rdata_o[EF_BIT]      = ef_q;
      rdata_o[EIE_BIT]     = eie_q;
      rdata_o[RE_BIT]      = re_q;
      rdata_o[TE_BIT]      = te_q;
      rdata_o[SEL_W-1:0]   = sel_q;
    end
  end

  assign irq_o     = ef_q & eie_q;
  assign sclk_oe_o = ~ext_mode;

  // R3
  en_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({re_q, te_q}));

  // R9
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!ef_q && !re_q));

  // R6
  tx_end_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(te_q) && !$past(ctrl_wr) |-> ef_q);

  // R8
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && !done |=> !ef_q);

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !shift |=> $stable(data_q));
endmodule

// File: tb/tb_sync_byte_port.sv
`timescale 1ns/1ps
module tb_sync_byte_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop = 1'b0;
  logic       addr = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sclk, sclk_oe, cts, sdo;
  logic       sclk_in = 1'b1;
  logic       man_sdi = 1'b1;
  logic       mon_int = 1'b1;
  logic       modem_en = 1'b0;
  logic       mon_sdi = 1'b1;
  logic       sdi;
  logic [7:0] rx_pat = '0;
  logic [7:0] cap = '0;
  logic       arm = 1'b0;
  logic       arm_seen = 1'b0;
  logic       sclk_prev = 1'b1;
  int         idx = 0;
  int         total = 0;
  int         bad = 0;

  assign sdi = mon_int ? mon_sdi : man_sdi;

  always #2 clk = ~clk;

  sync_byte_port #(.DIV_BASE(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_i(stop), .addr_i(addr),
    .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .sclk_o(sclk), .sclk_oe_o(sclk_oe), .sclk_i(sclk_in),
    .sdi_i(sdi), .modem_en_i(modem_en), .cts_o(cts), .sdo_o(sdo)
  );

  // internal-clock pin model: capture on rise, drive on fall
  always @(negedge clk) begin
    if (arm != arm_seen) begin
      idx = 0;
      arm_seen = arm;
    end
    if (!sclk_prev && sclk) cap = {sdo, cap[7:1]};
    if (sclk_prev && !sclk) begin
      mon_sdi = rx_pat[idx % 8];
      idx++;
    end
    sclk_prev = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek_ctrl(output logic [7:0] d);
    addr = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wait_ef(output int k);
    logic [7:0] c;
    k = 0;
    forever begin
      peek_ctrl(c);
      if (c[7]) break;
      @(negedge clk);
      k++;
      if (k > 6000) begin
        chk(1'b0, "R6 end flag timeout", k, 0);
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tx_run(input logic [7:0] v, input logic [2:0] s, output int k);
    bus_wr(1'b1, v);
    arm = ~arm;
    bus_wr(1'b0, 8'h10 | {5'd0, s});
    wait_ef(k);
  endtask

  task automatic rx_run(input logic [7:0] v, output int k);
    rx_pat = v;
    arm = ~arm;
    bus_wr(1'b0, 8'h20);
    wait_ef(k);
  endtask

  task automatic ext_edge(input logic b, output logic seen);
    @(negedge clk);
    sclk_in = 1'b0; man_sdi = b;
    idle(5);
    seen = sdo;
    sclk_in = 1'b1;
    idle(5);
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] c, d, shadow;
    logic seen;
    int k;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    peek_ctrl(c);
    chk(c == 8'h00, "R1 ctrl", c, 8'h00);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(sclk == 1'b1 && sdo == 1'b1, "R1 pins", {sclk, sdo}, 3);
    chk(sclk_oe == 1'b1, "R10 oe internal", sclk_oe, 1);
    chk(cts == 1'b1, "R11 cts idle", cts, 1);

    // R2 layout, read-only and unused bits
    bus_wr(1'b0, 8'hC3);
    peek_ctrl(c);
    chk(c == 8'h43, "R2 ef read-only", c, 8'h43);
    bus_wr(1'b0, 8'h0B);
    peek_ctrl(c);
    chk(c == 8'h03, "R2 bit3 zero", c, 8'h03);
    bus_wr(1'b0, 8'h00);

    // R4 R6 R8 transmit sweep
    for (int v = 0; v < 256; v++) begin
      tx_run(8'(v), 3'd0, k);
      chk(cap == 8'(v), "R4 tx order", cap, v);
      chk(k == 32, "R6 latency sel0", k, 32);
      peek_ctrl(c);
      chk(c[5:4] == 2'b00, "R6 te self clear", c, 0);
      chk(sdo == v[7], "R4 hold last", sdo, v[7]);
      bus_rd(1'b1, d);
      chk(d == 8'(v), "R12 data kept", d, v);
      peek_ctrl(c);
      chk(c[7] == 1'b0, "R8 read clears", c[7], 0);
    end

    // R5 receive sweep
    for (int v = 0; v < 256; v++) begin
      rx_run(8'(v), k);
      peek_ctrl(c);
      chk(c[5] == 1'b0 && c[7], "R6 re self clear", c, 8'h80);
      bus_rd(1'b1, d);
      chk(d == 8'(v), "R5 rx data", d, v);
    end

    // R6 R10 latency per divider
    for (int s = 0; s < 7; s++) begin
      tx_run(8'h5A, 3'(s), k);
      chk(k == 16 * (2 << s), "R6 R10 latency", k, 16 * (2 << s));
      chk(sclk_oe == 1'b1, "R10 oe", sclk_oe, 1);
      bus_rd(1'b1, d);
    end

    // R8 write clears, control access does not
    rx_run(8'hC3, k);
    peek_ctrl(c);
    bus_wr(1'b0, c & 8'h7F);
    peek_ctrl(c);
    chk(c[7] == 1'b1, "R8 ctrl keeps flag", c[7], 1);
    bus_wr(1'b1, 8'h11);
    peek_ctrl(c);
    chk(c[7] == 1'b0, "R8 write clears", c[7], 0);

    // R7 interrupt
    bus_wr(1'b1, 8'h77);
    arm = ~arm;
    bus_wr(1'b0, 8'h50);
    chk(irq == 1'b0, "R7 irq busy", irq, 0);
    wait_ef(k);
    chk(irq == 1'b1, "R7 irq set", irq, 1);
    bus_wr(1'b0, 8'h00);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    bus_wr(1'b0, 8'h40);
    chk(irq == 1'b1, "R7 irq unmask", irq, 1);
    bus_rd(1'b1, d);
    chk(irq == 1'b0, "R7 irq after clear", irq, 0);
    bus_wr(1'b0, 8'h00);

    // R3 both-set refusal
    bus_wr(1'b0, 8'h30);
    peek_ctrl(c);
    chk(c[5:4] == 2'b00, "R3 refuse idle", c, 0);
    bus_wr(1'b1, 8'hA5);
    arm = ~arm;
    bus_wr(1'b0, 8'h16);
    bus_wr(1'b0, 8'h36);
    peek_ctrl(c);
    chk(c[5:4] == 2'b01, "R3 refuse busy", c[5:4], 1);
    // R12 data write during transfer
    bus_wr(1'b1, 8'h3C);
    wait_ef(k);
    chk(cap == 8'hA5, "R12 tx unaffected", cap, 8'hA5);
    bus_rd(1'b1, d);
    chk(d == 8'hA5, "R12 write ignored", d, 8'hA5);

    // R9 stop aborts receive
    rx_pat = 8'h00;
    arm = ~arm;
    bus_wr(1'b0, 8'h66);
    idle(40);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    peek_ctrl(c);
    chk(c == 8'h46, "R9 stop abort", c, 8'h46);
    idle(300);
    peek_ctrl(c);
    chk(c == 8'h46, "R9 stays aborted", c, 8'h46);
    tx_run(8'h0F, 3'd0, k);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    peek_ctrl(c);
    chk(c[7] == 1'b0, "R9 stop clears flag", c[7], 0);

    // R11 modem sharing
    modem_en = 1'b1;
    rx_run(8'h00, k);
    bus_rd(1'b1, d);
    chk(d == 8'hFF, "R11 rx masked", d, 8'hFF);
    mon_int = 1'b0;
    man_sdi = 1'b0;
    #1 chk(cts == 1'b0, "R11 cts low", cts, 0);
    man_sdi = 1'b1;
    #1 chk(cts == 1'b1, "R11 cts high", cts, 1);
    modem_en = 1'b0;
    man_sdi = 1'b0;
    #1 chk(cts == 1'b1, "R11 cts off", cts, 1);

    // R10 external clock receive and transmit
    bus_wr(1'b0, 8'h27);
    chk(sclk_oe == 1'b0, "R10 oe external", sclk_oe, 0);
    shadow = 8'h96;
    for (int b = 0; b < 8; b++) ext_edge(shadow[b], seen);
    peek_ctrl(c);
    chk(c[7] && !c[5], "R10 ext rx done", c, 8'h87);
    chk(sclk == 1'b1, "R10 sclk idle ext", sclk, 1);
    bus_rd(1'b1, d);
    chk(d == 8'h96, "R10 R5 ext rx data", d, 8'h96);
    bus_wr(1'b1, 8'h5A);
    bus_wr(1'b0, 8'h17);
    d = '0;
    for (int b = 0; b < 8; b++) begin
      ext_edge(1'b0, seen);
      d[b] = seen;
    end
    chk(d == 8'h5A, "R10 R4 ext tx data", d, 8'h5A);
    peek_ctrl(c);
    chk(c[7] && !c[4], "R10 ext tx done", c, 8'h87);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule